// File: doc/BRIEF.md
# I2C Bus Monitor with Arbitration Detection

This block sits beside the SCL and SDA wires of a multi-master two-wire bus and only listens. It brings both wire levels into the system clock domain, recognises the START and STOP line conditions, and keeps a flag that marks the bus as occupied between them. It also tracks the position inside the current byte by counting SCL rising edges. It pulses once when the ninth edge arrives, which is eight data bits plus the acknowledge slot.

The local master's controller supplies the level it means to put on SDA and a flag saying that it is taking part in a transfer. When that master releases SDA (intends a 1) and the synchronized line reads 0 at an SCL rising edge, another master has won the wired-AND contest. The block then raises a sticky arbitration-lost flag. The acknowledge slot is not compared, because a receiver pulls SDA low there by design. Bit counting carries on after a loss, so the controller can keep clocking out the rest of the byte. The flag clears at the next START or STOP.

Top module: `i2c_bus_watch`

## Requirements
- R1: While rst_n is low and on the first cycle after it, start_seen, stop_seen, bus_busy, arb_lost and byte_done are all 0.
- R2: SDA falling while SCL stays high gives a one-cycle start_seen pulse. The pulse is visible SYNC_STAGES+1 clock edges after the edge that first samples the new SDA level (3 edges with the defaults).
- R3: SDA rising while SCL stays high gives a one-cycle stop_seen pulse with the same latency as R2. start_seen and stop_seen are never high together.
- R4: bus_busy becomes 1 on the same edge as start_seen and becomes 0 on the same edge as stop_seen. SDA changes while SCL is low produce neither pulse.
- R5: arb_lost becomes 1 when all of the following hold at a synchronized SCL rising edge: local_master_on is 1, local_sda_release is 1, the synchronized SDA is 0, and the rising edge is not the acknowledge slot (the 9th edge of a byte). It stays 0 when the master drives 0, when the master is not active, or when the line matches.
- R6: Once set, arb_lost stays 1 until the next START or STOP, and it is cleared on the same edge as start_seen or stop_seen.
- R7: While bus_busy is 1, byte_done pulses for one cycle on every 9th SCL rising edge counted from the last START. Counting continues unchanged after arbitration is lost.
- R8: A repeated START in the middle of a byte restarts the count, so the next byte_done comes 9 rising edges after that START.
- R9: SCL rising edges while bus_busy is 0 are not counted and produce no byte_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_line | input | 1 | Raw SCL wire level (asynchronous) |
| sda_line | input | 1 | Raw SDA wire level (asynchronous) |
| local_sda_release | input | 1 | Local master's SDA intent: 1 = release (high), 0 = pull low; synchronous to clk |
| local_master_on | input | 1 | Local master is taking part in the current transfer |
| start_seen | output | 1 | One-cycle pulse on a START condition |
| stop_seen | output | 1 | One-cycle pulse on a STOP condition |
| bus_busy | output | 1 | Bus occupied between START and STOP |
| arb_lost | output | 1 | Sticky arbitration-loss flag |
| byte_done | output | 1 | One-cycle pulse on the 9th SCL rising edge of a byte |

## Verification
The bench builds the monitor with SYNC_STAGES = 2 and BYTE_BITS = 8. This makes the 3-edge detection latency and the 9-edge byte boundary exact numbers that the reference model and the directed checks can predict to the cycle. With the default byte width, the bench can place a loss part-way through a data byte, confirm that the acknowledge slot is exempt, and cut a byte short with a repeated START inside it. With two synchronizer stages, SDA edges a few cycles from SCL edges are still resolved in the order they occurred.

// File: rtl/bw_pkg.sv
// Shared types and helpers for the bus monitor.
// Assumes line samples are already in the system clock domain when these
// helpers are applied.
package bw_pkg;

    // One sample of both bus wires.
    typedef struct packed {
        logic scl;
        logic sda;
    } bw_line_t;

    // Idle bus: both wires pulled high.
    localparam bw_line_t BW_LINE_IDLE = '{scl: 1'b1, sda: 1'b1};

    // START: clock high in both samples, data falls.
    function automatic logic bw_is_start(bw_line_t prev, bw_line_t cur);
        return prev.scl & cur.scl & prev.sda & ~cur.sda;
    endfunction

    // STOP: clock high in both samples, data rises.
    function automatic logic bw_is_stop(bw_line_t prev, bw_line_t cur);
        return prev.scl & cur.scl & ~prev.sda & cur.sda;
    endfunction

    // Clock rising between two samples.
    function automatic logic bw_is_rise(bw_line_t prev, bw_line_t cur);
        return ~prev.scl & cur.scl;
    endfunction

endpackage

// File: rtl/bw_sync.sv
// Multi-stage synchronizer for asynchronous wire levels.
// Assumes each bit is an independent level; no bus coherency is implied.
// Reset value is the idle bus level so that no false edge follows reset.
module bw_sync #(
    parameter int              STAGES  = 2,
    parameter int              WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the raw level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= d;
            end
        end else begin : g_next
            // Pass the level one stage further.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/bw_cond_detect.sv
// Line-condition detector: compares the current synchronized sample with
// the previous one, flags START, STOP and SCL rising edges, registers the
// START/STOP pulses and keeps the bus-occupied flag.
// Assumes the input sample is already synchronized to clk.
module bw_cond_detect
    import bw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bw_line_t line_cur,
    output logic     start_det,
    output logic     stop_det,
    output logic     scl_rise,
    output logic     start_pulse,
    output logic     stop_pulse,
    output logic     busy
);

    bw_line_t line_prev;

    // Hold the previous sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) line_prev <= BW_LINE_IDLE;
        else        line_prev <= line_cur;
    end

    // Combinational condition decode.
    always_comb begin
        start_det = bw_is_start(line_prev, line_cur);
        stop_det  = bw_is_stop(line_prev, line_cur);
        scl_rise  = bw_is_rise(line_prev, line_cur);
    end

    // Register the condition pulses and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
            busy        <= 1'b0;
        end else begin
            start_pulse <= start_det;
            stop_pulse  <= stop_det;
            if (start_det)     busy <= 1'b1;
            else if (stop_det) busy <= 1'b0;
        end
    end

endmodule

// File: rtl/bw_bitcount.sv
// Bit-position counter: counts SCL rising edges while the bus is occupied
// and pulses at the last slot of a byte (data bits plus acknowledge).
// Assumes restart is asserted on every START or STOP detection.
module bw_bitcount #(
    parameter int BYTE_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_rise,
    input  logic restart,
    input  logic counting,
    output logic ack_slot,
    output logic byte_end
);

    localparam int               CNT_W = $clog2(BYTE_BITS + 2);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(BYTE_BITS);

    logic [CNT_W-1:0] cnt;

    // The next rising edge lands on the acknowledge slot.
    assign ack_slot = (cnt == LAST);

    // Advance the slot count and flag the final slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            byte_end <= 1'b0;
        end else begin
            byte_end <= 1'b0;
            if (restart) begin
                cnt <= '0;
            end else if (scl_rise && counting) begin
                if (ack_slot) begin
                    cnt      <= '0;
                    byte_end <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bw_arb.sv
// Arbitration watcher: at each SCL rising edge outside the acknowledge
// slot, flags a loss when the local master releases SDA but the line reads
// low. The flag is sticky until the next START or STOP.
// Assumes the drive intent is held steady for the whole bit.
module bw_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_rise,
    input  logic sda_cur,
    input  logic release_sda,
    input  logic active,
    input  logic ack_slot,
    input  logic clear,
    output logic lost
);

    logic mismatch;

    // Released-high intent overridden by a low on the wire.
    assign mismatch = scl_rise & active & release_sda & ~sda_cur & ~ack_slot;

    // Sticky loss flag, cleared by a line condition.
    always_ff @(posedge clk) begin
        if (!rst_n)        lost <= 1'b0;
        else if (clear)    lost <= 1'b0;
        else if (mismatch) lost <= 1'b1;
    end

endmodule

// File: rtl/i2c_bus_watch.sv
// Passive two-wire bus monitor with arbitration-loss detection.
// Synchronizes the raw wires, detects START/STOP, tracks occupancy,
// counts byte slots and compares local SDA intent with the line.
// Assumes local_sda_release and local_master_on are synchronous to clk.
// Never drives the wires.
module i2c_bus_watch
    import bw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_BITS   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_line,
    input  logic sda_line,
    input  logic local_sda_release,
    input  logic local_master_on,
    output logic start_seen,
    output logic stop_seen,
    output logic bus_busy,
    output logic arb_lost,
    output logic byte_done
);

    bw_line_t line_raw;
    bw_line_t line_syn;
    logic     start_det;
    logic     stop_det;
    logic     scl_rise;
    logic     ack_slot;
    logic     cond_any;

    assign line_raw = '{scl: scl_line, sda: sda_line};
    assign cond_any = start_det | stop_det;

    bw_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   ($bits(bw_line_t)),
        .RST_VAL (BW_LINE_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_raw),
        .q     (line_syn)
    );

    bw_cond_detect u_cond (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_cur    (line_syn),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .scl_rise    (scl_rise),
        .start_pulse (start_seen),
        .stop_pulse  (stop_seen),
        .busy        (bus_busy)
    );

    bw_bitcount #(
        .BYTE_BITS (BYTE_BITS)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .restart  (cond_any),
        .counting (bus_busy),
        .ack_slot (ack_slot),
        .byte_end (byte_done)
    );

    bw_arb u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise    (scl_rise),
        .sda_cur     (line_syn.sda),
        .release_sda (local_sda_release),
        .active      (local_master_on),
        .ack_slot    (ack_slot),
        .clear       (cond_any),
        .lost        (arb_lost)
    );

endmodule

// File: rtl/bw_checker.sv
// Property checker for the bus monitor, attached by bind.
// Observes only top-level ports.
module bw_checker (
    input logic clk,
    input logic rst_n,
    input logic local_sda_release,
    input logic local_master_on,
    input logic start_seen,
    input logic stop_seen,
    input logic bus_busy,
    input logic arb_lost,
    input logic byte_done
);

    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> !start_seen);

    assert_cond_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_seen && stop_seen));

    assert_busy_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |-> bus_busy);

    assert_busy_off_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |-> !bus_busy);

    assert_loss_needs_intent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> $past(local_master_on && local_sda_release));

    assert_loss_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |=> (arb_lost || start_seen || stop_seen));

    assert_loss_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_seen || stop_seen) |-> !arb_lost);

    assert_byte_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

    assert_byte_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> bus_busy);

endmodule

bind i2c_bus_watch bw_checker u_bw_checker (
    .clk               (clk),
    .rst_n             (rst_n),
    .local_sda_release (local_sda_release),
    .local_master_on   (local_master_on),
    .start_seen        (start_seen),
    .stop_seen         (stop_seen),
    .bus_busy          (bus_busy),
    .arb_lost          (arb_lost),
    .byte_done         (byte_done)
);

// File: tb/tb_i2c_bus_watch.sv
module tb_i2c_bus_watch;

    localparam int SYNC_STAGES = 2;
    localparam int BYTE_BITS   = 8;
    localparam int STEP        = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_line = 1'b1;
    logic sda_line = 1'b1;
    logic local_sda_release = 1'b1;
    logic local_master_on = 1'b0;
    logic start_seen, stop_seen, bus_busy, arb_lost, byte_done;

    int tests = 0;
    int fails = 0;
    int byte_cnt = 0;
    int start_cnt = 0;
    bit timeout = 0;
    bit model_on = 0;

    always #4 clk = ~clk;

    i2c_bus_watch #(.SYNC_STAGES(SYNC_STAGES), .BYTE_BITS(BYTE_BITS)) dut (
        .clk(clk), .rst_n(rst_n), .scl_line(scl_line), .sda_line(sda_line),
        .local_sda_release(local_sda_release), .local_master_on(local_master_on),
        .start_seen(start_seen), .stop_seen(stop_seen), .bus_busy(bus_busy),
        .arb_lost(arb_lost), .byte_done(byte_done));

    // Reference model: history queue of raw samples, behavioural state.
    logic [1:0] hist [$];
    logic m_start, m_stop, m_busy, m_lost, m_byte;
    int   m_slot;

    always @(posedge clk) begin
        logic [1:0] cur, prv;
        logic rise, st, sp;
        if (!rst_n) begin
            hist = {};
            for (int i = 0; i < SYNC_STAGES + 2; i++) hist.push_front(2'b11);
            m_start = 0; m_stop = 0; m_busy = 0; m_lost = 0; m_byte = 0; m_slot = 0;
            model_on = 1;
        end else begin
            hist.push_front({scl_line, sda_line});
            cur = hist[SYNC_STAGES];
            prv = hist[SYNC_STAGES + 1];
            void'(hist.pop_back());
            rise = cur[1] && !prv[1];
            st = prv[1] && cur[1] && prv[0] && !cur[0];
            sp = prv[1] && cur[1] && !prv[0] && cur[0];
            m_byte = 0;
            if (st || sp) m_lost = 0;
            else if (rise && local_master_on && local_sda_release && !cur[0] && m_slot != BYTE_BITS)
                m_lost = 1;
            if (st || sp) m_slot = 0;
            else if (rise && m_busy) begin
                if (m_slot == BYTE_BITS) begin m_slot = 0; m_byte = 1; end
                else m_slot++;
            end
            if (st) m_busy = 1;
            else if (sp) m_busy = 0;
            m_start = st;
            m_stop = sp;
        end
    end

    task automatic chk(string req, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model and event counters.
    always @(negedge clk) begin
        if (model_on) begin
            chk("R2 start_seen model", start_seen, m_start);
            chk("R3 stop_seen model", stop_seen, m_stop);
            chk("R4 bus_busy model", bus_busy, m_busy);
            chk("R5 arb_lost model", arb_lost, m_lost);
            chk("R7 byte_done model", byte_done, m_byte);
            if (byte_done === 1'b1) byte_cnt++;
            if (start_seen === 1'b1) start_cnt++;
        end
    end

    task automatic step();
        repeat (STEP) @(negedge clk);
    endtask

    task automatic do_start();
        sda_line = 1'b0; step();
        scl_line = 1'b0; step();
    endtask

    task automatic do_rstart();
        local_sda_release = 1'b1;
        sda_line = 1'b1; step();
        scl_line = 1'b1; step();
        sda_line = 1'b0; step();
        scl_line = 1'b0; step();
    endtask

    task automatic do_stop();
        local_sda_release = 1'b0;
        sda_line = 1'b0; step();
        scl_line = 1'b1; step();
        sda_line = 1'b1; step();
    endtask

    // One bit: local intent and another device's level, wired-AND on the line.
    task automatic do_bit(logic mine, logic other);
        local_sda_release = mine;
        sda_line = mine & other; step();
        scl_line = 1'b1; step(); step();
        scl_line = 1'b0; step();
    endtask

    task automatic run_all();
        int b0;
        // R1 reset state
        repeat (5) @(negedge clk);
        chk("R1 start_seen in reset", start_seen, 1'b0);
        chk("R1 bus_busy in reset", bus_busy, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 arb_lost after reset", arb_lost, 1'b0);
        chk("R1 byte_done after reset", byte_done, 1'b0);
        chk("R1 stop_seen after reset", stop_seen, 1'b0);

        // R9 clocking on idle bus
        for (int i = 0; i < 10; i++) begin
            scl_line = 1'b0; step();
            scl_line = 1'b1; step();
        end
        chk_int("R9 no byte_done while idle", byte_cnt, 0);
        chk("R9 still idle", bus_busy, 1'b0);

        // R2 latency: change at this negedge, pulse after the 3rd edge
        sda_line = 1'b0;
        @(negedge clk); chk("R2 no pulse yet (1)", start_seen, 1'b0);
        @(negedge clk); chk("R2 no pulse yet (2)", start_seen, 1'b0);
        @(negedge clk); chk("R2 start pulse", start_seen, 1'b1);
        chk("R4 busy with start", bus_busy, 1'b1);
        @(negedge clk); chk("R2 pulse ends", start_seen, 1'b0);
        scl_line = 1'b0; step();

        // Clean byte 0xA5, slave ACK low: no loss (R5 ack slot exempt)
        local_master_on = 1'b1;
        b0 = byte_cnt;
        for (int i = 7; i >= 0; i--) do_bit(8'hA5 >> i, 1'b1);
        do_bit(1'b1, 1'b0);
        chk("R5 no loss on clean byte and ack", arb_lost, 1'b0);
        chk_int("R7 one byte_done", byte_cnt, b0 + 1);

        // Lost byte: local 0xF0, rival 0xD0, differs at third bit
        b0 = byte_cnt;
        for (int i = 7; i >= 0; i--) begin
            do_bit(8'hF0 >> i, 8'hD0 >> i);
            if (i == 6) chk("R5 no loss before mismatch", arb_lost, 1'b0);
            if (i == 5) chk("R5 loss at mismatch", arb_lost, 1'b1);
        end
        do_bit(1'b1, 1'b0);
        chk("R6 loss held to byte end", arb_lost, 1'b1);
        chk_int("R7 byte counted after loss", byte_cnt, b0 + 1);

        // STOP clears loss and busy
        do_stop();
        chk("R6 loss cleared by stop", arb_lost, 1'b0);
        chk("R4 idle after stop", bus_busy, 1'b0);

        // Inactive master with released intent on a low line: no loss
        start_cnt = 0;
        do_start();
        chk_int("R4 one start pulse", start_cnt, 1);
        local_master_on = 1'b0;
        for (int i = 0; i < 9; i++) do_bit(1'b1, 1'b0);
        chk("R5 inactive master never loses", arb_lost, 1'b0);

        // Master drives 0: no loss
        local_master_on = 1'b1;
        for (int i = 0; i < 4; i++) do_bit(1'b0, 1'b1);
        chk("R5 driving low never loses", arb_lost, 1'b0);

        // R8 repeated START restarts the count
        do_rstart();
        b0 = byte_cnt;
        for (int i = 0; i < 5; i++) do_bit(1'b1, 1'b1);
        do_rstart();
        for (int i = 0; i < 8; i++) do_bit(1'b1, 1'b1);
        chk_int("R8 no byte_done before 9th edge", byte_cnt, b0);
        do_bit(1'b1, 1'b0);
        chk_int("R8 byte_done on 9th edge", byte_cnt, b0 + 1);

        // Loss then repeated START clears it
        do_bit(1'b1, 1'b0);
        chk("R5 loss on low line", arb_lost, 1'b1);
        do_rstart();
        chk("R6 loss cleared by start", arb_lost, 1'b0);
        do_stop();
        chk("R3 bus idle at end", bus_busy, 1'b0);
        step();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timeout = 1;
            end
        join_any
        if (timeout) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule